// File: doc/BRIEF.md
# Power-Up and Power-Mode Sequencer

This block steps the chip from the moment its supply comes up to full operation. A supply-good comparator flag and two active-high mode-select pins enter through a reset-aware synchronizer. The mode pins reset to high, which matches their on-chip pull-ups. While the supply flag is low, the block holds the chip in an inactive state. Once the flag is seen high, a hold-off timer gives the supply time to settle, and the block then always lands in sleep.

From sleep, the pin pattern "first pin high, second pin low" starts a timed wake transition. At the end of that transition, the block enters normal mode. On that same cycle it strobes a register-default load and pulses a done event for the interrupt logic. On entry to normal mode, the block also raises a DSP-idle flag, which stays high until the run-control logic releases it. Raising both pins again sends the chip back to sleep. A loss of supply sends it to the inactive state from anywhere. The active-low reset pin forces the inactive state asynchronously. Both durations are clock-count parameters.

States and transitions:
- OFF to HOLD when the supply is good.
- HOLD to SLEEP when the hold-off expires.
- SLEEP to WAKE on a wake request.
- WAKE to NORMAL when the wake timer expires.
- WAKE to SLEEP on an abort.
- NORMAL to SLEEP on a sleep request.
- Any state to OFF on supply loss.

Top module: `pwrseq_top`

## Requirements
- R1: While `rst_n` is low, the outputs are `pwr_state`=0 (OFF), `xfer_done`=0, `reg_default_load`=0 and `dsp_idle`=1. This also holds when reset arrives in mid-operation.
- R2: While `supply_ok` is low, `pwr_state` stays 0 (OFF), whatever the mode pins do.
- R3: Input changes reach the state machine after SYNC_STAGES clock edges. After `supply_ok` rises, `pwr_state` becomes 1 (HOLD) on the third edge with SYNC_STAGES=2. It stays at 1 for exactly HOLD_CYC cycles and then becomes 2 (SLEEP).
- R4: In SLEEP, the state does not change while both pins are high. It also does not change while `pm0_pin` is low.
- R5: In SLEEP, `pm0_pin`=1 with `pm1_pin`=0 moves the block to 3 (WAKE). It stays there for exactly WAKE_CYC cycles and then moves to 4 (NORMAL).
- R6: `xfer_done` is high for exactly one cycle, the first cycle of NORMAL, and is never high at any other time.
- R7: `reg_default_load` is high for exactly one cycle on every entry to NORMAL, in the same cycle as `xfer_done`.
- R8: If `pm1_pin` is already low when HOLD ends, SLEEP lasts exactly one cycle and WAKE follows without further input.
- R9: When `supply_ok` falls, the block reaches OFF from any state within SYNC_STAGES+1 edges. A wake transition cut off this way gives no `xfer_done`.
- R10: `dsp_idle` is 1 on entry to NORMAL and remains 1 until `dsp_run` is sampled high in NORMAL. It drops one cycle after that sample and stays low while NORMAL lasts. Outside NORMAL, `dsp_idle` is 1 and `dsp_run` has no effect.
- R11: In NORMAL, both pins high return the block to SLEEP. A later wake gives a fresh `xfer_done` and `reg_default_load`.
- R12: In WAKE, both pins high abort the transition back to SLEEP, with no `xfer_done` or `reg_default_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset pin |
| supply_ok | input | 1 | Supply-good comparator flag, asynchronous |
| pm0_pin | input | 1 | Mode-select pin 0, active high, asynchronous |
| pm1_pin | input | 1 | Mode-select pin 1, active high, asynchronous |
| dsp_run | input | 1 | Release request from the run-control logic |
| pwr_state | output | 3 | Power state: 0 OFF, 1 HOLD, 2 SLEEP, 3 WAKE, 4 NORMAL |
| reg_default_load | output | 1 | One-cycle strobe that returns the configuration registers to their defaults |
| dsp_idle | output | 1 | DSP held idle |
| xfer_done | output | 1 | One-cycle transition-done event for the interrupt logic |

## Verification
The bench measures the dwell in HOLD and in WAKE cycle by cycle. A timer that is off by one, or that restarts while the block is in a state, shows up as a wrong count. It drops the supply during a wake transition and aborts a wake with a sleep request, the two places where a careless design would still fire `xfer_done` or `reg_default_load`. It holds `pm1_pin` low from power-up to confirm that SLEEP cannot be skipped and lasts exactly one cycle. It also drives `dsp_run` outside NORMAL, where a design that gated the flag poorly would clear `dsp_idle` too early.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PS_OFF    = 3'd0,
        PS_HOLD   = 3'd1,
        PS_SLEEP  = 3'd2,
        PS_WAKE   = 3'd3,
        PS_NORMAL = 3'd4
    } pwr_state_e;

    // pin pattern that asks for the low-power sleep state
    function automatic logic sleep_req(input logic pm0, input logic pm1);
        return pm0 & pm1;
    endfunction

    // pin pattern that asks for full operation
    function automatic logic wake_req(input logic pm0, input logic pm1);
        return pm0 & ~pm1;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int TOT_W = WIDTH * STAGES;

    logic [TOT_W-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= RST_VAL;
                else        shreg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= {STAGES{RST_VAL}};
                else        shreg <= {shreg[TOT_W-WIDTH-1:0], d};
            end
        end
    endgenerate

    assign q = shreg[TOT_W-1 -: WIDTH];

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R3 R5: a loaded value is taken as is
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    // R3 R5: an expired timer rests at zero until reloaded
    tmr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int HOLD_CYC = 20,
    parameter int WAKE_CYC = 30,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_ok,
    input  logic             pm0,
    input  logic             pm1,
    input  logic             dsp_run,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output pwr_state_e       state,
    output logic             done,
    output logic             reg_load,
    output logic             dsp_idle
);

    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);

    pwr_state_e nxt;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            PS_OFF:    if (sup_ok) nxt = PS_HOLD;
            PS_HOLD:   if (tmr_zero) nxt = PS_SLEEP;
            PS_SLEEP:  if (wake_req(pm0, pm1)) nxt = PS_WAKE;
            PS_WAKE: begin
                if (sleep_req(pm0, pm1)) nxt = PS_SLEEP;
                else if (tmr_zero)       nxt = PS_NORMAL;
            end
            PS_NORMAL: if (sleep_req(pm0, pm1)) nxt = PS_SLEEP;
            default:   nxt = PS_OFF;
        endcase
        if (!sup_ok) nxt = PS_OFF;
    end

    // timer start on entry to a timed state
    always_comb begin
        tmr_load = ((nxt == PS_HOLD) && (state != PS_HOLD)) ||
                   ((nxt == PS_WAKE) && (state != PS_WAKE));
        tmr_val  = (nxt == PS_HOLD) ? HOLD_LAST : WAKE_LAST;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_OFF;
        else        state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            reg_load <= 1'b0;
            dsp_idle <= 1'b1;
        end else begin
            done     <= (state == PS_WAKE) && (nxt == PS_NORMAL);
            reg_load <= (state == PS_WAKE) && (nxt == PS_NORMAL);
            if (nxt != PS_NORMAL || state != PS_NORMAL)
                dsp_idle <= 1'b1;
            else if (dsp_run)
                dsp_idle <= 1'b0;
        end
    end

    // R9
    sup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> (state == PS_OFF));

    // R3
    off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_OFF && state != PS_OFF) |-> (state == PS_HOLD));

    // R5
    normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != PS_NORMAL && state == PS_NORMAL) |-> ($past(state) == PS_WAKE));

    // R6 R7
    entry_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_WAKE && state == PS_NORMAL) |-> (done && reg_load));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_where_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == PS_NORMAL));

    // R10
    idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != PS_NORMAL && state == PS_NORMAL) |-> dsp_idle);

    // R10
    idle_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_NORMAL) |-> dsp_idle);

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int HOLD_CYC    = 20,
    parameter int WAKE_CYC    = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pm0_pin,
    input  logic       pm1_pin,
    input  logic       dsp_run,
    output logic [2:0] pwr_state,
    output logic       reg_default_load,
    output logic       dsp_idle,
    output logic       xfer_done
);

    localparam int MAX_CYC = (HOLD_CYC > WAKE_CYC) ? HOLD_CYC : WAKE_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic [2:0]       pins_sync;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    pwr_state_e       state;

    // bit 2 = pm1, bit 1 = pm0, bit 0 = supply; mode pins rest high
    pwrseq_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pm1_pin, pm0_pin, supply_ok}),
        .q     (pins_sync)
    );

    pwrseq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    pwrseq_fsm #(
        .HOLD_CYC (HOLD_CYC),
        .WAKE_CYC (WAKE_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sup_ok   (pins_sync[0]),
        .pm0      (pins_sync[1]),
        .pm1      (pins_sync[2]),
        .dsp_run  (dsp_run),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .state    (state),
        .done     (xfer_done),
        .reg_load (reg_default_load),
        .dsp_idle (dsp_idle)
    );

    assign pwr_state = state;

endmodule

// File: tb/test_pwrseq_top.sv
module test_pwrseq_top;

    localparam int HC = 20;
    localparam int WC = 30;
    localparam int SS = 2;

    localparam int S_OFF = 0, S_HOLD = 1, S_SLEEP = 2, S_WAKE = 3, S_NORM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       pm0_pin = 1'b1;
    logic       pm1_pin = 1'b1;
    logic       dsp_run = 1'b0;
    logic [2:0] pwr_state;
    logic       reg_default_load;
    logic       dsp_idle;
    logic       xfer_done;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int load_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwrseq_top #(
        .HOLD_CYC    (HC),
        .WAKE_CYC    (WC),
        .SYNC_STAGES (SS)
    ) i_pwrseq_top (
        .clk              (clk),
        .rst_n            (rst_n),
        .supply_ok        (supply_ok),
        .pm0_pin          (pm0_pin),
        .pm1_pin          (pm1_pin),
        .dsp_run          (dsp_run),
        .pwr_state        (pwr_state),
        .reg_default_load (reg_default_load),
        .dsp_idle         (dsp_idle),
        .xfer_done        (xfer_done)
    );

    always @(posedge clk) begin
        if (xfer_done)        done_cnt <= done_cnt + 1;
        if (reg_default_load) load_cnt <= load_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // count consecutive samples spent in one state, stop at the next state
    task automatic run_len(input int st, input int maxn, output int len);
        len = 0;
        while (int'(pwr_state) == st && len < maxn) begin
            len++;
            tick(1);
        end
    endtask

    // from SLEEP with both pins high: request wake and check the full path
    task automatic do_wake(input string req);
        int len;
        int d0;
        int l0;
        d0 = done_cnt;
        l0 = load_cnt;
        pm0_pin = 1'b1;
        pm1_pin = 1'b0;
        tick(SS);
        check({req, " R5 still sleep"}, int'(pwr_state), S_SLEEP);
        tick(1);
        check({req, " R5 wake entered"}, int'(pwr_state), S_WAKE);
        run_len(S_WAKE, 200, len);
        check({req, " R5 wake length"}, len, WC);
        check({req, " R5 normal"}, int'(pwr_state), S_NORM);
        check({req, " R6 done high"}, int'(xfer_done), 1);
        check({req, " R7 load high"}, int'(reg_default_load), 1);
        check({req, " R10 idle on entry"}, int'(dsp_idle), 1);
        tick(1);
        check({req, " R6 done one cycle"}, int'(xfer_done), 0);
        check({req, " R7 load one cycle"}, int'(reg_default_load), 0);
        check({req, " R6 done count"}, done_cnt - d0, 1);
        check({req, " R7 load count"}, load_cnt - l0, 1);
    endtask

    task automatic t_reset;
        tick(3);
        check("R1 state", int'(pwr_state), S_OFF);
        check("R1 done", int'(xfer_done), 0);
        check("R1 load", int'(reg_default_load), 0);
        check("R1 idle", int'(dsp_idle), 1);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic t_off_pins;
        int wrong = 0;
        pm1_pin = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (i == 6) pm0_pin = 1'b0;
            tick(1);
            if (int'(pwr_state) != S_OFF) wrong++;
        end
        check("R2 off while supply low", wrong, 0);
        pm0_pin = 1'b1;
        pm1_pin = 1'b1;
        tick(3);
    endtask

    task automatic t_powerup;
        int len;
        int wrong = 0;
        supply_ok = 1'b1;
        tick(SS);
        check("R3 off before sync", int'(pwr_state), S_OFF);
        tick(1);
        check("R3 hold entered", int'(pwr_state), S_HOLD);
        run_len(S_HOLD, 200, len);
        check("R3 hold length", len, HC);
        check("R3 lands in sleep", int'(pwr_state), S_SLEEP);
        for (int i = 0; i < 15; i++) begin
            tick(1);
            if (int'(pwr_state) != S_SLEEP) wrong++;
        end
        check("R4 sleep with pins high", wrong, 0);
        pm0_pin = 1'b0;
        pm1_pin = 1'b0;
        wrong = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (int'(pwr_state) != S_SLEEP) wrong++;
        end
        check("R4 sleep with pm0 low", wrong, 0);
        pm0_pin = 1'b1;
        pm1_pin = 1'b1;
        tick(SS + 1);
    endtask

    task automatic t_dsp_release;
        tick(10);
        check("R10 idle held", int'(dsp_idle), 1);
        dsp_run = 1'b1;
        tick(1);
        check("R10 idle released", int'(dsp_idle), 0);
        dsp_run = 1'b0;
        tick(5);
        check("R10 stays released", int'(dsp_idle), 0);
    endtask

    task automatic t_back_to_sleep;
        pm1_pin = 1'b1;
        tick(SS);
        check("R11 normal before sync", int'(pwr_state), S_NORM);
        tick(1);
        check("R11 back to sleep", int'(pwr_state), S_SLEEP);
        check("R10 idle in sleep", int'(dsp_idle), 1);
        dsp_run = 1'b1;
        tick(4);
        check("R10 run ignored outside normal", int'(dsp_idle), 1);
        dsp_run = 1'b0;
        do_wake("R11");
    endtask

    task automatic t_wake_abort;
        int d0;
        int l0;
        pm1_pin = 1'b1;
        tick(SS + 1);
        check("R12 sleep", int'(pwr_state), S_SLEEP);
        d0 = done_cnt;
        l0 = load_cnt;
        pm1_pin = 1'b0;
        tick(SS + 1);
        check("R12 wake", int'(pwr_state), S_WAKE);
        tick(5);
        pm1_pin = 1'b1;
        tick(SS);
        check("R12 still wake", int'(pwr_state), S_WAKE);
        tick(1);
        check("R12 aborted to sleep", int'(pwr_state), S_SLEEP);
        tick(WC + 5);
        check("R12 stays sleep", int'(pwr_state), S_SLEEP);
        check("R12 no done", done_cnt - d0, 0);
        check("R12 no load", load_cnt - l0, 0);
    endtask

    task automatic t_supply_drop;
        int len;
        int d0;
        do_wake("R9");
        supply_ok = 1'b0;
        tick(SS);
        check("R9 normal before sync", int'(pwr_state), S_NORM);
        tick(1);
        check("R9 off from normal", int'(pwr_state), S_OFF);
        supply_ok = 1'b1;
        tick(SS + 1);
        check("R9 hold again", int'(pwr_state), S_HOLD);
        run_len(S_HOLD, 200, len);
        check("R3 hold length again", len, HC);
        d0 = done_cnt;
        pm1_pin = 1'b0;
        tick(SS + 1);
        check("R9 wake", int'(pwr_state), S_WAKE);
        tick(5);
        supply_ok = 1'b0;
        tick(SS + 1);
        check("R9 off from wake", int'(pwr_state), S_OFF);
        tick(WC);
        check("R9 no done after drop", done_cnt - d0, 0);
        check("R9 stays off", int'(pwr_state), S_OFF);
    endtask

    task automatic t_early_pm1;
        int len;
        int d0;
        pm0_pin = 1'b1;
        pm1_pin = 1'b0;
        tick(4);
        d0 = done_cnt;
        supply_ok = 1'b1;
        tick(SS + 1);
        check("R8 hold", int'(pwr_state), S_HOLD);
        run_len(S_HOLD, 200, len);
        check("R8 hold length", len, HC);
        check("R8 passes sleep", int'(pwr_state), S_SLEEP);
        tick(1);
        check("R8 sleep one cycle", int'(pwr_state), S_WAKE);
        run_len(S_WAKE, 200, len);
        check("R8 wake length", len, WC);
        check("R8 normal", int'(pwr_state), S_NORM);
        check("R8 done", int'(xfer_done), 1);
        tick(2);
        check("R8 one done", done_cnt - d0, 1);
    endtask

    task automatic t_mid_reset;
        rst_n = 1'b0;
        #1;
        check("R1 async reset state", int'(pwr_state), S_OFF);
        check("R1 async reset idle", int'(dsp_idle), 1);
        tick(2);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_off_pins();
        t_powerup();
        do_wake("R5");
        t_dsp_release();
        t_back_to_sleep();
        t_wake_abort();
        t_supply_drop();
        t_early_pm1();
        t_mid_reset();
        tick(2);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule